// File: doc/BRIEF.md
# Burst SRAM Cycle-Start and Write-Enable Decoder

This block sits in front of a synchronous burst memory array. On every rising clock edge it looks at three chip enables, two address strobes, the burst advance input and the write controls, and decides whether a new access begins, whether the device deselects, or whether a burst already in progress continues. It also decides whether the cycle is a read or a write and which byte lanes are written.

Two strobes can open a cycle. The processor strobe is gated by the master chip enable and always starts a read. The controller strobe is honoured only while the processor strobe is not starting a cycle. Its write controls, sampled on the same edge, choose between read and write. Once a burst is open, the write controls are sampled on every later edge, so a burst that began as a read can carry writes. The global write enable overrides the per-lane controls.

All decisions are registered. They appear on the outputs for the clock cycle after the edge that sampled the inputs. The address counter, the array and the data drivers are outside the block.

Top module: `sram_cycle_decode`

## Requirements
- R1: While reset is low, and on the first cycle after reset, every output is 0 and no burst is open. A continuation request right after reset produces no activity.
- R2: A processor strobe low with the master enable low and all chip enables active produces load_addr=1 with cyc_write=0 and lane_we=0. This holds whatever the controller strobe and the write controls show.
- R3: A controller strobe low while the processor strobe is high and all chip enables are active produces load_addr=1. On that edge, the write controls sampled decide cyc_write and lane_we.
- R4: A processor strobe low while the master enable is high starts nothing. If the controller strobe is high on that edge, the edge acts as a burst continuation. If the controller strobe is low, the edge is a deselect.
- R5: A start strobe (an unblocked processor strobe, or a controller strobe) seen while any chip enable is inactive gives desel=1, load_addr=0, lane_we=0, and closes the burst.
- R6: Global write low on a write-qualified edge gives cyc_write=1 and lane_we all ones, whatever the byte controls show.
- R7: With global write high, byte write low and some lane enables low, lane_we bit i is 1 exactly when lane_wr_n bit i is 0, and cyc_write=1.
- R8: With global write high and either byte write high or all lane enables high, the cycle is a read: cyc_write=0 and lane_we=0.
- R9: Inside an open burst, an edge with no start gives adv_addr=1 when adv_n is low and adv_addr=0 when adv_n is high. The write controls on that edge apply per R6 to R8, so a burst begun as a read can write.
- R10: Outside an open burst (after a deselect), an edge with no start gives all outputs 0, even with adv_n and the write controls asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_main_n | input | 1 | Master chip enable, active low; gates the processor strobe |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write enable, active low |
| bwr_n | input | 1 | Byte write enable, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low; bit i is lane i |
| load_addr | output | 1 | New external address accepted |
| adv_addr | output | 1 | Advance the burst address |
| desel | output | 1 | Device deselected, burst closed |
| cyc_write | output | 1 | Current cycle is a write |
| lane_we | output | LANES | Lanes written this cycle, active high |

## Verification
The decoder is driven with each strobe alone, with both strobes together, and with the processor strobe blocked by the master enable. This separates the processor path from the controller path and shows that a blocked processor strobe falls through to either a continuation or a deselect. Each chip enable is dropped in turn on a start edge to show that any single one forces a deselect. The write controls are swept through global write, partial lane masks, byte write off and all lanes off, both on controller starts and inside a burst begun as a read. Continuation edges are issued inside and outside a burst, and after a reset in mid-burst, to show that advance and writes act only while a burst is open.

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_main_n,
  input  logic             ce_hi,
  input  logic             ce_lo_n,
  input  logic             pstrb_n,
  input  logic             cstrb_n,
  input  logic             adv_n,
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic             load_addr,
  output logic             adv_addr,
  output logic             desel,
  output logic             cyc_write,
  output logic [LANES-1:0] lane_we
);

  logic             in_burst;
  logic             chips_on;
  logic             p_go;
  logic             c_go;
  logic             start;
  logic             take;
  logic             drop;
  logic             wr_req;
  logic             wr_now;
  logic [LANES-1:0] wr_mask;

  assign chips_on = !ce_main_n && ce_hi && !ce_lo_n;
  assign p_go     = !pstrb_n && !ce_main_n;
  assign c_go     = !cstrb_n && !p_go;
  assign start    = p_go || c_go;
  assign take     = start && chips_on;
  assign drop     = start && !chips_on;

  assign wr_req  = !gwr_n || (!bwr_n && !(&lane_wr_n));
  assign wr_mask = !gwr_n ? {LANES{1'b1}} : (bwr_n ? {LANES{1'b0}} : ~lane_wr_n);
  assign wr_now  = take ? (c_go && wr_req) : (!start && in_burst && wr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_burst  <= 1'b0;
      load_addr <= 1'b0;
      adv_addr  <= 1'b0;
      desel     <= 1'b0;
      cyc_write <= 1'b0;
      lane_we   <= '0;
    end else begin
      in_burst  <= start ? take : in_burst;
      load_addr <= take;
      adv_addr  <= !start && in_burst && !adv_n;
      desel     <= drop;
      cyc_write <= wr_now;
      lane_we   <= wr_now ? wr_mask : '0;
    end
  end

endmodule

// File: rtl/sram_cycle_decode_chk.sv
module sram_cycle_decode_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_main_n,
  input logic             ce_hi,
  input logic             ce_lo_n,
  input logic             pstrb_n,
  input logic             cstrb_n,
  input logic             adv_n,
  input logic             gwr_n,
  input logic             load_addr,
  input logic             adv_addr,
  input logic             desel,
  input logic             cyc_write,
  input logic [LANES-1:0] lane_we
);

  // R2
  p_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!pstrb_n && !ce_main_n && ce_hi && !ce_lo_n))
    |-> (load_addr && !cyc_write && lane_we == '0));

  // R4
  p_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!pstrb_n && ce_main_n && cstrb_n))
    |-> (!load_addr && !desel));

  // R5
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(((!pstrb_n && !ce_main_n) || !cstrb_n) && !(!ce_main_n && ce_hi && !ce_lo_n)))
    |-> (desel && !load_addr && lane_we == '0));

  // R6
  gw_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pstrb_n && !cstrb_n && !ce_main_n && ce_hi && !ce_lo_n && !gwr_n))
    |-> (cyc_write && lane_we == '1));

  // R9
  adv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_addr |-> ($past(!adv_n) && !load_addr && !desel));

  // R10
  after_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> (load_addr || desel || (!adv_addr && !cyc_write)));

  // R5
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_addr, adv_addr, desel}));

endmodule

bind sram_cycle_decode sram_cycle_decode_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_main_n(ce_main_n), .ce_hi(ce_hi),
  .ce_lo_n(ce_lo_n), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n),
  .gwr_n(gwr_n), .load_addr(load_addr), .adv_addr(adv_addr), .desel(desel),
  .cyc_write(cyc_write), .lane_we(lane_we)
);

// File: tb/sram_cycle_decode_test.sv
`timescale 1ns/1ps
module sram_cycle_decode_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_main_n = 1'b0, ce_hi = 1'b1, ce_lo_n = 1'b0;
  logic       pstrb_n = 1'b1, cstrb_n = 1'b1, adv_n = 1'b1;
  logic       gwr_n = 1'b1, bwr_n = 1'b1;
  logic [3:0] lane_wr_n = 4'hF;
  logic       load_addr, adv_addr, desel, cyc_write;
  logic [3:0] lane_we;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sram_cycle_decode #(.LANES(4)) uut (
    .clk(clk), .rst_n(rst_n), .ce_main_n(ce_main_n), .ce_hi(ce_hi),
    .ce_lo_n(ce_lo_n), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n),
    .load_addr(load_addr), .adv_addr(adv_addr), .desel(desel),
    .cyc_write(cyc_write), .lane_we(lane_we)
  );

  // fields: ce_main_n ce_hi ce_lo_n | pstrb_n cstrb_n adv_n | gwr_n bwr_n | lane_wr_n
  //         | expected load adv desel write | expected lane_we
  localparam int NV = 18;
  localparam logic [19:0] VEC [NV] = '{
    20'b010_110_01_1111_0000_0000,  // R10 no burst yet
    20'b010_001_00_0000_1000_0000,  // R2 both strobes, writes asserted: read
    20'b010_110_11_1111_0100_0000,  // R9 advance
    20'b010_110_10_1010_0101_0101,  // R7 R9 partial write inside read burst
    20'b010_111_01_1111_0001_1111,  // R6 R9 suspend, global write
    20'b110_010_11_1111_0100_0000,  // R4 blocked strobe continues burst
    20'b110_001_11_1111_0010_0000,  // R4 blocked strobe plus controller: deselect
    20'b010_110_10_0000_0000_0000,  // R10 idle after deselect
    20'b010_101_10_0110_1001_1001,  // R3 R7 controller start write
    20'b010_101_11_0000_1000_0000,  // R8 byte write off: read
    20'b010_101_10_1111_1000_0000,  // R8 all lanes off: read
    20'b010_101_01_1111_1001_1111,  // R3 R6 global write overrides lanes
    20'b000_101_11_1111_0010_0000,  // R5 active-high enable low
    20'b010_110_01_0000_0000_0000,  // R10 idle after deselect
    20'b010_011_11_1111_1000_0000,  // R2 processor start
    20'b011_011_11_1111_0010_0000,  // R5 active-low enable high
    20'b010_011_01_0000_1000_0000,  // R2 global write ignored on processor start
    20'b010_110_10_1110_0101_0001   // R7 single lane
  };

  function automatic logic [7:0] outs();
    return {load_addr, adv_addr, desel, cyc_write, lane_we};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic apply(input logic [11:0] v);
    {ce_main_n, ce_hi, ce_lo_n, pstrb_n, cstrb_n, adv_n, gwr_n, bwr_n, lane_wr_n} = v;
  endtask

  initial begin
    #5 check("R1 in reset", outs(), 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after reset", outs(), 8'h00);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i][19:8]);
      @(posedge clk); #1;
      check($sformatf("vector %0d", i), outs(), VEC[i][7:0]);
    end
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 reset mid-burst", outs(), 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    apply(12'b010_110_01_0000);
    @(posedge clk); #1 check("R1 burst closed by reset", outs(), 8'h00);
    @(negedge clk);
    apply(12'b010_101_10_1100);
    @(posedge clk); #1 check("R3 R7 start after reset", outs(), 8'b1001_0011);
    @(negedge clk);
    apply(12'b010_110_11_1111);
    @(posedge clk); #1 check("R9 advance after restart", outs(), 8'b0100_0000);
    @(negedge clk);
    apply(12'b010_111_11_1111);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule